// File: doc/BRIEF.md
# Power-up Reset Time-out Sequencer

This block keeps a processor core in reset after a power-on, a brown-out or a wake from sleep. It releases reset only after a chain of timed stages has completed. The stages always run in the same order: a power-up delay, an oscillator start-up count and a PLL lock delay. Each stage is skipped according to the configuration, the oscillator mode and the cause of the reset. The power-up and PLL delays count pulses of a slow internal tick. The oscillator stage counts cycles of the main clock.

Analog detection is outside the block and arrives as digital flags: a power-on pulse, a brown-out comparator flag and a wake event. The external active-low reset pin passes through a two-flop synchroniser. The core reset output is asserted while that synchronised pin is low or while the sequencer has not reached its done stage. The time-outs therefore keep running while the pin is held low, and execution starts as soon as the pin is released. A stage code is brought out so that the stage order and the stage lengths can be observed.

Top module: `rst_seq_top`

## Requirements
- R1: While `arst_n` is low or `por_active` is high, `stage` is 0 (idle) and `core_rst` is 1.
- R2: After `por_active` falls, the stages run in the fixed order power-up (1), oscillator start-up (2), PLL lock (3), then done (4). A disabled stage is skipped.
- R3: The power-up stage ends on the `PWRT_TICKS`-th `slow_tick` pulse after it is entered. When `cfg_pwrt_en` is 0, the stage is bypassed.
- R4: The oscillator stage lasts exactly `OSC_CYCLES` clock cycles. It runs only for `osc_mode` 2'b00, 2'b01 or 2'b10 (crystal or resonator modes; 2'b11 is internal RC), and only after a power-on or a wake.
- R5: With `cfg_pll_en` set, the PLL stage lasts `PLL_TICKS` tick pulses. With `cfg_pll_en` clear, the PLL stage is skipped.
- R6: When `cfg_bor_en` is 1 and `bor_flag` is high, `stage` becomes 5 (brown-out) on the next cycle from any stage. It stays 5 and keeps `core_rst` high while the flag stays high.
- R7: When the brown-out flag clears, a fresh power-up stage runs (if enabled) and is followed by the PLL stage (if enabled). The oscillator stage is skipped in this case. A new brown-out during that power-up stage returns to stage 5, and the full power-up delay restarts after the flag clears again.
- R8: When `cfg_bor_en` is 0, `bor_flag` has no effect on `stage` or `core_rst`.
- R9: In RC mode with the power-up timer and the PLL disabled, `stage` reaches 4 on the first clock edge after `por_active` falls.
- R10: `core_rst` is high whenever `stage` is not 4. If `ext_rst_n` is still low at done, `core_rst` falls on the second rising clock edge after `ext_rst_n` rises.
- R11: A `wake_evt` pulse in stage 4 runs the oscillator stage (crystal modes only) and then the PLL stage (if enabled), without a power-up stage. In RC mode with the PLL disabled, the block stays in stage 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| arst_n | input | 1 | Asynchronous active-low register reset |
| por_active | input | 1 | Power-on pulse, high while power is coming up |
| bor_flag | input | 1 | Brown-out comparator flag, high when the supply is low |
| ext_rst_n | input | 1 | External active-low reset pin, asynchronous |
| wake_evt | input | 1 | One-cycle wake-from-sleep event |
| osc_mode | input | 2 | Oscillator mode: 00/01/10 crystal or resonator, 11 internal RC |
| cfg_pwrt_en | input | 1 | Enables the power-up delay stage |
| cfg_bor_en | input | 1 | Enables brown-out reset |
| cfg_pll_en | input | 1 | Enables the PLL lock stage |
| slow_tick | input | 1 | One-cycle pulse from the slow internal time base |
| core_rst | output | 1 | Active-high reset to the core |
| stage | output | 3 | Current stage: 0 idle, 1 power-up, 2 oscillator, 3 PLL, 4 done, 5 brown-out |

## Verification
The sequence is run with every stage enabled, in RC mode with nothing enabled, with the power-up timer bypassed and with the PLL bypassed. Comparing the stages that are visited shows whether each skip condition is decoded from the right input. A double brown-out, where the flag re-asserts partway through the power-up delay, shows whether the delay truly restarts rather than resumes. The same run shows whether the oscillator stage is correctly left out after a brown-out. Wake events in crystal and RC modes, a masked brown-out, and holding the external pin low past done each test a single path: the wake path alone, the mask alone, and the pin path that is independent of the time-outs.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PWRUP = 3'd1,
    ST_OSC   = 3'd2,
    ST_PLL   = 3'd3,
    ST_DONE  = 3'd4,
    ST_BROWN = 3'd5
  } seq_state_e;

  localparam logic [1:0] MODE_RC = 2'b11;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_in};
  end

  assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = inc & (cnt_q == limit - 1'b1);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int PWRT_TICKS = 72,
  parameter int OSC_CYCLES = 1024,
  parameter int PLL_TICKS  = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             por_active,
  input  logic             bor_flag,
  input  logic             wake_evt,
  input  logic [1:0]       osc_mode,
  input  logic             cfg_pwrt_en,
  input  logic             cfg_bor_en,
  input  logic             cfg_pll_en,
  input  logic             slow_tick,
  input  logic             t_last,
  output logic             t_clr,
  output logic             t_inc,
  output logic [CNT_W-1:0] t_limit,
  output seq_state_e       state
);
  seq_state_e state_q, state_d;
  logic       osc_ok_q, osc_ok_d;
  logic       crystal;
  seq_state_e after_pwrup, after_start;

  assign crystal     = (osc_mode != MODE_RC);
  assign after_pwrup = (osc_ok_q && crystal) ? ST_OSC :
                       (cfg_pll_en ? ST_PLL : ST_DONE);
  assign after_start = cfg_pwrt_en ? ST_PWRUP : after_pwrup;

  always_comb begin
    state_d  = state_q;
    osc_ok_d = osc_ok_q;
    if (por_active) begin
      state_d  = ST_IDLE;
      osc_ok_d = 1'b1;
    end else if (cfg_bor_en && bor_flag) begin
      state_d  = ST_BROWN;
      osc_ok_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_BROWN: state_d = after_start;
        ST_PWRUP: if (t_last) state_d = after_pwrup;
        ST_OSC:   if (t_last) state_d = cfg_pll_en ? ST_PLL : ST_DONE;
        ST_PLL:   if (t_last) state_d = ST_DONE;
        ST_DONE: begin
          if (wake_evt) begin
            if (crystal) begin
              state_d  = ST_OSC;
              osc_ok_d = 1'b1;
            end else if (cfg_pll_en) begin
              state_d = ST_PLL;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    t_inc   = 1'b0;
    t_limit = CNT_W'(PWRT_TICKS);
    unique case (state_q)
      ST_PWRUP: begin t_inc = slow_tick; t_limit = CNT_W'(PWRT_TICKS); end
      ST_OSC:   begin t_inc = 1'b1;      t_limit = CNT_W'(OSC_CYCLES); end
      ST_PLL:   begin t_inc = slow_tick; t_limit = CNT_W'(PLL_TICKS);  end
      default:  begin t_inc = 1'b0;      t_limit = CNT_W'(PWRT_TICKS); end
    endcase
  end

  assign t_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= ST_IDLE;
      osc_ok_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      osc_ok_q <= osc_ok_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OSC_CYCLES = 1024,
  parameter int PLL_TICKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       por_active,
  input  logic       bor_flag,
  input  logic       ext_rst_n,
  input  logic       wake_evt,
  input  logic [1:0] osc_mode,
  input  logic       cfg_pwrt_en,
  input  logic       cfg_bor_en,
  input  logic       cfg_pll_en,
  input  logic       slow_tick,
  output logic       core_rst,
  output logic [2:0] stage
);
  localparam int MAX_A = (PWRT_TICKS > OSC_CYCLES) ? PWRT_TICKS : OSC_CYCLES;
  localparam int MAX_V = (MAX_A > PLL_TICKS) ? MAX_A : PLL_TICKS;
  localparam int CNT_W = $clog2(MAX_V + 1);

  logic             pin_hi;
  logic             t_clr, t_inc, t_last;
  logic [CNT_W-1:0] t_limit;
  seq_state_e       state;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_in(ext_rst_n), .q_out(pin_hi)
  );

  rst_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .arst_n(arst_n), .clr(t_clr), .inc(t_inc),
    .limit(t_limit), .last(t_last)
  );

  rst_seq_fsm #(
    .CNT_W(CNT_W), .PWRT_TICKS(PWRT_TICKS),
    .OSC_CYCLES(OSC_CYCLES), .PLL_TICKS(PLL_TICKS)
  ) u_fsm (
    .clk(clk), .arst_n(arst_n), .por_active(por_active),
    .bor_flag(bor_flag), .wake_evt(wake_evt), .osc_mode(osc_mode),
    .cfg_pwrt_en(cfg_pwrt_en), .cfg_bor_en(cfg_bor_en),
    .cfg_pll_en(cfg_pll_en), .slow_tick(slow_tick), .t_last(t_last),
    .t_clr(t_clr), .t_inc(t_inc), .t_limit(t_limit), .state(state)
  );

  assign core_rst = ~pin_hi | (state != ST_DONE);
  assign stage    = state;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       por_active,
  input logic       bor_flag,
  input logic       cfg_bor_en,
  input logic       core_rst,
  input logic [2:0] stage
);
  // R1
  idle_on_por_chk: assert property (@(posedge clk) disable iff (!arst_n)
    por_active |=> stage == 3'd0);

  // R6
  brown_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cfg_bor_en && bor_flag && !por_active) |=> stage == 3'd5);

  // R8
  bor_masked_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!cfg_bor_en && !por_active && stage != 3'd5) |=> stage != 3'd5);

  // R10
  rst_until_done_chk: assert property (@(posedge clk) disable iff (!arst_n)
    stage != 3'd4 |-> core_rst);

  // R4
  osc_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (stage == 3'd2 && $past(stage) != 3'd2) |->
      ($past(stage) == 3'd0 || $past(stage) == 3'd1 || $past(stage) == 3'd4));

  // R7
  pwrup_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (stage == 3'd1 && $past(stage) != 3'd1) |->
      ($past(stage) == 3'd0 || $past(stage) == 3'd5));
endmodule

bind rst_seq_top rst_seq_chk chk_i (
  .clk(clk), .arst_n(arst_n), .por_active(por_active), .bor_flag(bor_flag),
  .cfg_bor_en(cfg_bor_en), .core_rst(core_rst), .stage(stage)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PWRT  = 5;
  localparam int OSCN  = 1024;
  localparam int PLLN  = 3;
  localparam int TDIV  = 8;

  logic clk = 1'b0;
  logic arst_n, por_active, bor_flag, ext_rst_n, wake_evt;
  logic [1:0] osc_mode;
  logic cfg_pwrt_en, cfg_bor_en, cfg_pll_en, slow_tick;
  logic core_rst;
  logic [2:0] stage;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_seq_top #(.PWRT_TICKS(PWRT), .OSC_CYCLES(OSCN), .PLL_TICKS(PLLN)) dut_i (
    .clk(clk), .arst_n(arst_n), .por_active(por_active), .bor_flag(bor_flag),
    .ext_rst_n(ext_rst_n), .wake_evt(wake_evt), .osc_mode(osc_mode),
    .cfg_pwrt_en(cfg_pwrt_en), .cfg_bor_en(cfg_bor_en), .cfg_pll_en(cfg_pll_en),
    .slow_tick(slow_tick), .core_rst(core_rst), .stage(stage)
  );

  typedef struct {
    int    stg;
    int    kind;   // 0 no length, 1 ticks, 2 clocks
    int    len;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(input int s, input int k, input int l, input string r);
    exp_t e;
    e.stg = s; e.kind = k; e.len = l; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (stage == 3'd4) break;
    end
  endtask

  // slow tick: one pulse every TDIV clocks, driven at negedge
  initial begin
    slow_tick = 1'b0;
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        slow_tick = (i == TDIV - 1);
      end
    end
  end

  // monitor: compares each finished stage with the scoreboard
  initial begin
    int prev = 0;
    int nclk = 0;
    int ntick = 0;
    forever begin
      @(negedge clk);
      #1;
      if (arst_n) begin
        if (int'(stage) != prev) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected stage exit", prev, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.stg == prev, {e.req, " stage order"}, prev, e.stg);
            if (e.kind == 1)
              check(ntick == e.len, {e.req, " tick length"}, ntick, e.len);
            else if (e.kind == 2)
              check(nclk == e.len, {e.req, " clock length"}, nclk, e.len);
          end
          prev  = int'(stage);
          nclk  = 1;
          ntick = slow_tick ? 1 : 0;
        end else begin
          nclk++;
          if (slow_tick) ntick++;
        end
      end
    end
  end

  // driver
  initial begin
    arst_n = 1'b0; por_active = 1'b1; bor_flag = 1'b0; ext_rst_n = 1'b0;
    wake_evt = 1'b0; osc_mode = 2'b01; cfg_pwrt_en = 1'b1;
    cfg_bor_en = 1'b1; cfg_pll_en = 1'b1;
    repeat (3) @(negedge clk);
    check(stage == 3'd0, "R1 stage in reset", stage, 0);
    check(core_rst == 1'b1, "R1 core_rst in reset", core_rst, 1);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(stage == 3'd0, "R1 stage under por", stage, 0);

    // all stages, external pin held low (R2 R3 R4 R5 R10)
    push(0, 0, 0, "R2"); push(1, 1, PWRT, "R3");
    push(2, 2, OSCN, "R4"); push(3, 1, PLLN, "R5");
    por_active = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    check(core_rst == 1'b1, "R10 pin low holds reset", core_rst, 1);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check(core_rst == 1'b1, "R10 one edge after release", core_rst, 1);
    @(negedge clk);
    check(core_rst == 1'b0, "R10 two edges after release", core_rst, 0);

    // RC mode, nothing enabled (R9)
    osc_mode = 2'b11; cfg_pwrt_en = 1'b0; cfg_pll_en = 1'b0;
    push(4, 0, 0, "R2"); push(0, 0, 0, "R9");
    por_active = 1'b1;
    repeat (3) @(negedge clk);
    por_active = 1'b0;
    @(negedge clk);
    check(stage == 3'd4, "R9 immediate release", stage, 4);

    // HS, power-up timer bypassed (R3 R4 R5)
    osc_mode = 2'b10; cfg_pll_en = 1'b1;
    push(4, 0, 0, "R2"); push(0, 0, 0, "R3");
    push(2, 2, OSCN, "R4"); push(3, 1, PLLN, "R5");
    por_active = 1'b1; repeat (2) @(negedge clk); por_active = 1'b0;
    wait_done();

    // LP, PLL bypassed (R5)
    osc_mode = 2'b00; cfg_pwrt_en = 1'b1; cfg_pll_en = 1'b0;
    push(4, 0, 0, "R2"); push(0, 0, 0, "R2");
    push(1, 1, PWRT, "R3"); push(2, 2, OSCN, "R5");
    por_active = 1'b1; repeat (2) @(negedge clk); por_active = 1'b0;
    wait_done();

    // double brown-out (R6 R7)
    osc_mode = 2'b01; cfg_pll_en = 1'b1;
    push(4, 0, 0, "R6"); push(5, 0, 0, "R6"); push(1, 0, 0, "R7");
    push(5, 0, 0, "R7"); push(1, 1, PWRT, "R7"); push(3, 1, PLLN, "R7");
    bor_flag = 1'b1;
    repeat (5) @(negedge clk);
    check(stage == 3'd5, "R6 brown-out stage", stage, 5);
    check(core_rst == 1'b1, "R6 reset held", core_rst, 1);
    bor_flag = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (stage == 3'd1) break;
    end
    repeat (16) @(negedge clk);
    bor_flag = 1'b1;
    repeat (3) @(negedge clk);
    check(stage == 3'd5, "R7 re-entry to brown-out", stage, 5);
    bor_flag = 1'b0;
    wait_done();

    // masked brown-out (R8)
    cfg_bor_en = 1'b0;
    bor_flag = 1'b1;
    repeat (20) @(negedge clk);
    check(stage == 3'd4, "R8 stage unchanged", stage, 4);
    check(core_rst == 1'b0, "R8 reset not asserted", core_rst, 0);
    bor_flag = 1'b0;

    // wake, crystal mode (R11)
    push(4, 0, 0, "R11"); push(2, 2, OSCN, "R11"); push(3, 1, PLLN, "R11");
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    check(stage == 3'd2, "R11 wake enters oscillator", stage, 2);
    wait_done();

    // wake, RC mode, PLL off (R11)
    osc_mode = 2'b11; cfg_pll_en = 1'b0;
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    repeat (3) @(negedge clk);
    check(stage == 3'd4, "R11 RC wake stays done", stage, 4);
    check(core_rst == 1'b0, "R11 RC wake no reset", core_rst, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule